// File: doc/BRIEF.md
# Event Counter Performance Monitor

This block counts hardware events for software profiling. It has four 32-bit counters. Each counter has a 5-bit selector that picks one line of a 32-bit event vector. Each line carries single-cycle pulses. Selector value 0 means the counter holds its value.

Software reaches every register through a special-purpose-register port. The port carries a register number, write and read strobes, write data and read data. Two mode registers hold the selectors and the interrupt controls. The second mode register also has a read-only alias for user-level code.

A counter counts as overflowed when its top bit is 1. When an enabled counter overflows, the block raises an interrupt request. An external enable, supplied by the processor, decides when that request is signalled as an exception. An optional freeze stops all counting as soon as the interrupt condition appears.

Top module: `evtmon_top`

## Requirements
- R1: After reset, every register reads 0, and both `irq_pending` and `irq_req` are 0.
- R2: The registers sit at these register numbers, and each reads back what was written:
  - mode register A at 952, with bits [4:0] selecting counter 1, [9:5] selecting counter 2, [16] global interrupt enable, [17] counter-1 interrupt control, [18] shared interrupt control for counters 2 to 4, and [19] freeze.
  - mode register B at 956.
  - counters 1 to 4 at 953, 954, 957 and 958.
  - All other bits of the mode registers read as 0.
- R3: Register 940 reads the same value as mode register B. A write to 940 changes nothing.
- R4: A counter adds one in a cycle when its selector S is nonzero and event bit S is 1. With S = 0, the counter holds its value.
- R5: Mode register B bits [31:27] select the event for counter 3, and bits [26:22] select the event for counter 4.
- R6: A counter at 0x7FFF_FFFF that gets an event becomes 0x8000_0000, and is then overflowed.
- R7: An overflowed counter keeps counting in bits [30:0] and keeps bit 31 set. From 0xFFFF_FFFF it goes to 0x8000_0000.
- R8: `irq_pending` is 1 exactly when the global enable is set and at least one of these holds:
  - counter 1 has bit 31 set and the counter-1 control is set.
  - any of counters 2 to 4 has bit 31 set and the shared control is set.
- R9: `irq_req` equals `irq_pending` while `ext_irq_en` is 1, and is 0 while `ext_irq_en` is 0.
- R10: While freeze is set and `irq_pending` is 1, no counter changes except by a register write.
- R11: A register write to a counter takes priority over an event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spr_num | input | 10 | Register number |
| spr_wr | input | 1 | Write strobe |
| spr_rd | input | 1 | Read strobe |
| spr_wdata | input | 32 | Write data |
| spr_rdata | output | 32 | Read data (0 when not reading) |
| evt_vec | input | 32 | Event pulses, one per line |
| ext_irq_en | input | 1 | External interrupt enable from the processor |
| irq_pending | output | 1 | Interrupt condition recorded |
| irq_req | output | 1 | Interrupt signalled to the processor |

## Verification
The hardest cases to reach are the crossing into the top bit and the wrap inside the overflowed range. From reset, either would take billions of events. The stimulus therefore preloads the counters through their register numbers with 0x7FFF_FFFF and 0xFFFF_FFFF, and then sends a single event pulse. Freeze is tested by the same route: preloading makes the interrupt condition appear in one step. The bench then sends further events and checks that the counters stay unchanged.

// File: rtl/evtmon_pkg.sv
package evtmon_pkg;
  localparam int unsigned CNT_W   = 32;
  localparam int unsigned SEL_W   = 5;
  localparam int unsigned N_CNT   = 4;
  localparam int unsigned NUM_W   = 10;

  // mode register A field positions
  localparam int unsigned A_SEL1_LO = 0;
  localparam int unsigned A_SEL2_LO = 5;
  localparam int unsigned A_GIE     = 16;
  localparam int unsigned A_C1CTL   = 17;
  localparam int unsigned A_CNCTL   = 18;
  localparam int unsigned A_FRZ     = 19;
  localparam logic [CNT_W-1:0] A_MASK = 32'h000F_03FF;

  // mode register B field positions
  localparam int unsigned B_SEL3_LO = 27;
  localparam int unsigned B_SEL4_LO = 22;
  localparam logic [CNT_W-1:0] B_MASK = 32'hFFC0_0000;

  typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/evtmon_ctrl.sv
module evtmon_ctrl
  import evtmon_pkg::*;
#(
  parameter logic [NUM_W-1:0] NUM_A   = 10'd952,
  parameter logic [NUM_W-1:0] NUM_B   = 10'd956,
  parameter logic [NUM_W-1:0] NUM_USR = 10'd940
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [NUM_W-1:0] spr_num,
  input  logic             spr_wr,
  input  logic [CNT_W-1:0] spr_wdata,
  output logic [CNT_W-1:0] mode_a,
  output logic [CNT_W-1:0] mode_b,
  output sel_t             sel [N_CNT],
  output logic             gie,
  output logic             c1ctl,
  output logic             cnctl,
  output logic             frz
);
  logic [CNT_W-1:0] a_q, a_d, b_q, b_d;
  logic             a_en, b_en;

  assign a_en = spr_wr && (spr_num == NUM_A);
  assign b_en = spr_wr && (spr_num == NUM_B);

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (a_en) a_d = spr_wdata & A_MASK;
    if (b_en) b_d = spr_wdata & B_MASK;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (a_en) a_q <= a_d;
      if (b_en) b_q <= b_d;
    end
  end

  assign mode_a = a_q;
  assign mode_b = b_q;
  assign sel[0] = a_q[A_SEL1_LO +: SEL_W];
  assign sel[1] = a_q[A_SEL2_LO +: SEL_W];
  assign sel[2] = b_q[B_SEL3_LO +: SEL_W];
  assign sel[3] = b_q[B_SEL4_LO +: SEL_W];
  assign gie    = a_q[A_GIE];
  assign c1ctl  = a_q[A_C1CTL];
  assign cnctl  = a_q[A_CNCTL];
  assign frz    = a_q[A_FRZ];

  // R3
  usr_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (spr_wr && spr_num == NUM_USR) |=> $stable(b_q));
endmodule

// File: rtl/evtmon_counter.sv
module evtmon_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         evt,
  input  logic         freeze,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         inc_en, upd_en;

  assign inc_en = evt && !freeze;
  assign upd_en = wr_en || inc_en;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_en) begin
      cnt_d = wdata;
    end else if (inc_en) begin
      if (cnt_q[W-1]) cnt_d = {1'b1, cnt_q[W-2:0] + 1'b1};
      else            cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (upd_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (cnt_q[W-1] && !wr_en) |=> cnt_q[W-1]);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!wr_en && (!evt || freeze)) |=> $stable(cnt_q));
  // R11
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |=> (cnt_q == $past(wdata)));
  // R6
  step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!wr_en && evt && !freeze && !cnt_q[W-1]) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/evtmon_irq.sv
module evtmon_irq #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [N-1:0] top_bits,
  input  logic         gie,
  input  logic         c1ctl,
  input  logic         cnctl,
  input  logic         ext_en,
  output logic         pending,
  output logic         req
);
  logic hit1, hitn;

  assign hit1    = c1ctl && top_bits[0];
  assign hitn    = cnctl && (|top_bits[N-1:1]);
  assign pending = gie && (hit1 || hitn);
  assign req     = pending && ext_en;

  // R9
  req_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ($rose(ext_en) && pending) |-> req);
endmodule

// File: rtl/evtmon_top.sv
module evtmon_top
  import evtmon_pkg::*;
#(
  parameter logic [NUM_W-1:0] NUM_A   = 10'd952,
  parameter logic [NUM_W-1:0] NUM_B   = 10'd956,
  parameter logic [NUM_W-1:0] NUM_USR = 10'd940,
  parameter logic [NUM_W-1:0] NUM_C1  = 10'd953,
  parameter logic [NUM_W-1:0] NUM_C2  = 10'd954,
  parameter logic [NUM_W-1:0] NUM_C3  = 10'd957,
  parameter logic [NUM_W-1:0] NUM_C4  = 10'd958
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_W-1:0] spr_num,
  input  logic             spr_wr,
  input  logic             spr_rd,
  input  logic [CNT_W-1:0] spr_wdata,
  output logic [CNT_W-1:0] spr_rdata,
  input  logic [CNT_W-1:0] evt_vec,
  input  logic             ext_irq_en,
  output logic             irq_pending,
  output logic             irq_req
);
  localparam logic [NUM_W-1:0] CNT_NUM [N_CNT] = '{NUM_C1, NUM_C2, NUM_C3, NUM_C4};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [CNT_W-1:0] mode_a, mode_b;
  sel_t             sel [N_CNT];
  logic             gie, c1ctl, cnctl, frz, frozen;
  logic [CNT_W-1:0] cnt [N_CNT];
  logic [N_CNT-1:0] top_bits;

  evtmon_ctrl #(.NUM_A(NUM_A), .NUM_B(NUM_B), .NUM_USR(NUM_USR)) ctrl_i (
    .clk(clk), .rst_ni(rst_ni), .spr_num(spr_num), .spr_wr(spr_wr),
    .spr_wdata(spr_wdata), .mode_a(mode_a), .mode_b(mode_b), .sel(sel),
    .gie(gie), .c1ctl(c1ctl), .cnctl(cnctl), .frz(frz)
  );

  assign frozen = frz && irq_pending;

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    logic evt_hit, wr_hit;
    assign evt_hit = (sel[i] != '0) && evt_vec[sel[i]];
    assign wr_hit  = spr_wr && (spr_num == CNT_NUM[i]);
    evtmon_counter #(.W(CNT_W)) cnt_i (
      .clk(clk), .rst_ni(rst_ni), .wr_en(wr_hit), .wdata(spr_wdata),
      .evt(evt_hit), .freeze(frozen), .cnt(cnt[i])
    );
    assign top_bits[i] = cnt[i][CNT_W-1];
  end

  evtmon_irq #(.N(N_CNT)) irq_i (
    .clk(clk), .rst_ni(rst_ni), .top_bits(top_bits), .gie(gie),
    .c1ctl(c1ctl), .cnctl(cnctl), .ext_en(ext_irq_en),
    .pending(irq_pending), .req(irq_req)
  );

  always_comb begin
    spr_rdata = '0;
    if (spr_rd) begin
      if (spr_num == NUM_A) spr_rdata = mode_a;
      if (spr_num == NUM_B || spr_num == NUM_USR) spr_rdata = mode_b;
      for (int i = 0; i < N_CNT; i++)
        if (spr_num == CNT_NUM[i]) spr_rdata = cnt[i];
    end
  end

  // R8
  pending_source_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_pending |-> (gie && (|top_bits)));
  // R10
  freeze_all_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (frozen && !spr_wr) |=> ($stable(cnt[0]) && $stable(cnt[1]) &&
                             $stable(cnt[2]) && $stable(cnt[3])));
endmodule

// File: tb/evtmon_top_tb.sv
module evtmon_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_E = 2'd2;

  // op, register number, data, expected
  localparam logic [75:0] VEC [NVEC] = '{
    {OP_W, 10'd952, 32'h0000_0003, 32'h0},
    {OP_W, 10'd956, 32'h29C0_00FF, 32'h0},
    {OP_R, 10'd956, 32'h0,         32'h29C0_0000},
    {OP_R, 10'd940, 32'h0,         32'h29C0_0000},
    {OP_W, 10'd940, 32'h0,         32'h0},
    {OP_R, 10'd956, 32'h0,         32'h29C0_0000},
    {OP_E, 10'd0,   32'h0000_0028, 32'h0},
    {OP_R, 10'd953, 32'h0,         32'h1},
    {OP_R, 10'd954, 32'h0,         32'h0},
    {OP_R, 10'd957, 32'h0,         32'h1},
    {OP_R, 10'd958, 32'h0,         32'h0},
    {OP_E, 10'd0,   32'h0000_0080, 32'h0},
    {OP_R, 10'd958, 32'h0,         32'h1},
    {OP_E, 10'd0,   32'h0000_0001, 32'h0},
    {OP_R, 10'd953, 32'h0,         32'h1}
  };
  localparam string VEC_REQ [NVEC] = '{"R2","R5","R2","R3","R3","R3","R4",
    "R4","R4","R5","R5","R5","R5","R4","R4"};

  logic        clk, rst_n, spr_wr, spr_rd, ext_irq_en;
  logic [9:0]  spr_num;
  logic [31:0] spr_wdata, spr_rdata, evt_vec;
  logic        irq_pending, irq_req;
  int checks = 0, errors = 0;
  bit done = 0;

  evtmon_top dut_i (
    .clk(clk), .rst_n(rst_n), .spr_num(spr_num), .spr_wr(spr_wr),
    .spr_rd(spr_rd), .spr_wdata(spr_wdata), .spr_rdata(spr_rdata),
    .evt_vec(evt_vec), .ext_irq_en(ext_irq_en),
    .irq_pending(irq_pending), .irq_req(irq_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] num, input logic [31:0] d, input logic [31:0] ev = 0);
    @(negedge clk);
    spr_num = num; spr_wdata = d; spr_wr = 1'b1; evt_vec = ev;
    @(negedge clk);
    spr_wr = 1'b0; evt_vec = '0;
  endtask

  task automatic rd(input string req, input logic [9:0] num, input logic [31:0] exp);
    @(negedge clk);
    spr_num = num; spr_rd = 1'b1;
    #1 check(req, spr_rdata, exp);
    spr_rd = 1'b0;
  endtask

  task automatic ev(input logic [31:0] v);
    @(negedge clk);
    evt_vec = v;
    @(negedge clk);
    evt_vec = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; spr_wr = 0; spr_rd = 0; spr_num = '0; spr_wdata = '0;
    evt_vec = '0; ext_irq_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd("R1", 10'd952, 0); rd("R1", 10'd956, 0); rd("R1", 10'd953, 0);
    rd("R1", 10'd954, 0); rd("R1", 10'd957, 0); rd("R1", 10'd958, 0);
    check("R1", {31'd0, irq_pending}, 0);
    check("R1", {31'd0, irq_req}, 0);

    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][75:74])
        OP_W: wr(VEC[i][73:64], VEC[i][63:32]);
        OP_R: rd(VEC_REQ[i], VEC[i][73:64], VEC[i][31:0]);
        default: ev(VEC[i][63:32]);
      endcase
    end

    // R6 crossing into the top bit
    wr(10'd953, 32'h7FFF_FFFF); ev(32'h8);
    rd("R6", 10'd953, 32'h8000_0000);
    check("R8", {31'd0, irq_pending}, 0);
    // R7 keeps counting, wraps within low bits
    ev(32'h8); rd("R7", 10'd953, 32'h8000_0001);
    wr(10'd953, 32'hFFFF_FFFF); ev(32'h8);
    rd("R7", 10'd953, 32'h8000_0000);

    // R8 / R9 interrupt gating
    wr(10'd952, 32'h0003_0003);
    #1 check("R8", {31'd0, irq_pending}, 1);
    check("R9", {31'd0, irq_req}, 0);
    ext_irq_en = 1'b1;
    #1 check("R9", {31'd0, irq_req}, 1);
    wr(10'd953, 32'h0);
    #1 check("R8", {31'd0, irq_pending}, 0);
    wr(10'd952, 32'h0005_0003); wr(10'd957, 32'h8000_0000);
    #1 check("R8", {31'd0, irq_pending}, 1);
    wr(10'd952, 32'h0003_0003);
    #1 check("R8", {31'd0, irq_pending}, 0);

    // R10 freeze
    wr(10'd957, 32'h0);
    wr(10'd952, 32'h000B_0003);
    wr(10'd953, 32'h7FFF_FFFF);
    ev(32'h28);
    rd("R10", 10'd953, 32'h8000_0000); rd("R10", 10'd957, 32'h1);
    ev(32'h28);
    rd("R10", 10'd953, 32'h8000_0000); rd("R10", 10'd957, 32'h1);

    // R11 write beats event
    wr(10'd952, 32'h0000_0003);
    wr(10'd953, 32'h10, 32'h8);
    rd("R11", 10'd953, 32'h10);

    // R2 reserved bits of mode register A
    wr(10'd952, 32'hFFFF_FFFF);
    rd("R2", 10'd952, 32'h000F_03FF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule